// File: doc/BRIEF.md
# Serial ADC readout controller

This block sits on the host side of a 12-bit serial analog-to-digital converter that has a chip-select, a serial clock, an active-low shutdown pin and one data output. It also uses that data output to flag the end of a conversion. One pulse on `start_i` runs a complete cycle. The controller releases shutdown and waits for the converter to wake up. It then pulls chip-select low to start a conversion and holds the serial clock low. It watches the data line until the converter raises it. After that it sends a 16-clock read frame, captures the 12 result bits MSB first, and returns the word with a one-cycle `valid_o` strobe.

If the data line never shows a proper end-of-conversion, a timeout ends the attempt, releases chip-select and pulses `err_o`. Between cycles the converter is held in shutdown. An idle gap is always enforced before the next start request is accepted. Four parameters set all timing in system clock cycles: the half serial-clock period, the wake-up wait, the conversion timeout and the idle gap. The defaults suit a 125 MHz system clock: 256 ns clock phases, a 4 us wake-up, a 15 us timeout and a 256 ns gap.

The state machine has five states:
- IDLE → WAKE on `start_i`.
- WAKE → CONV when the wake-up count expires.
- CONV → SHIFT when the end-of-conversion flag is seen.
- CONV → GAP on timeout.
- SHIFT → GAP after the last falling clock edge of the frame.
- GAP → IDLE when the idle count expires.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset, chip-select is high, the serial clock is low, shutdown is asserted (low), and `busy_o`, `valid_o` and `err_o` are low.
- R2: A start request seen in IDLE raises `busy_o` and releases shutdown on the next cycle. Chip-select stays high for exactly WAKE_CYC cycles and then goes low.
- R3: While chip-select is low and end-of-conversion has not yet been accepted, the serial clock stays low.
- R4: End-of-conversion is accepted only when the data line is high after the controller has seen it low at least once in the current conversion. A high level before the first low is ignored.
- R5: After acceptance, the serial clock starts low and toggles every HALF_CYC cycles, giving exactly 16 rising edges per frame.
- R6: Rising edges 2 through 13 sample the data bits MSB first; rising edge 1 and edges 14 to 16 are discarded. In the cycle that follows the 16th falling edge, chip-select returns high, `data_o` holds the 12-bit word and `valid_o` is high for one cycle.
- R7: If end-of-conversion is not accepted within TMO_CYC cycles of chip-select going low, chip-select returns high and `err_o` pulses for one cycle. `valid_o` stays low and `data_o` keeps its previous value.
- R8: After a frame or an abort, `busy_o` stays high for IDLE_CYC cycles with chip-select high. Start requests made while `busy_o` is high are ignored.
- R9: Shutdown is asserted (low) whenever the controller is not in the wake, conversion or read phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Request one conversion-and-read cycle |
| busy_o | output | 1 | High from acceptance of a request to the end of the idle gap |
| data_o | output | DATA_W | Last captured conversion result |
| valid_o | output | 1 | One-cycle strobe when `data_o` is updated |
| err_o | output | 1 | One-cycle strobe on conversion timeout |
| adc_cs_n_o | output | 1 | Converter chip-select, active low |
| adc_sclk_o | output | 1 | Converter serial clock |
| adc_shdn_n_o | output | 1 | Converter shutdown, active low |
| adc_dout_i | input | 1 | Converter data and end-of-conversion flag |

## Verification
The hardest case to reach is a data line that reads high at the moment chip-select falls, before the converter drives it low. A naive poller would take that level as an instant end-of-conversion. The bench's converter model has an adjustable lag during which it leaves the line pulled high after chip-select drops. In one run it never drives the line low at all, which must end in a timeout rather than a read frame. A second start pulse is issued in the middle of every frame, and the request line is also held high across two cycles in a row. Together these exercise the ignore-while-busy rule and the idle gap.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_WAKE  = 3'd1,
        ST_CONV  = 3'd2,
        ST_SHIFT = 3'd3,
        ST_GAP   = 3'd4
    } rd_state_e;
endpackage

// File: rtl/adc_rd_tmr.sv
// Free-running phase timer: counts from zero, flags the last cycle of a
// phase of length lim, restarts on clr.
module adc_rd_tmr #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [CNT_W-1:0] lim,
    output logic             hit
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   cnt_q <= '0;
        else if (clr) cnt_q <= '0;
        else          cnt_q <= cnt_q + 1'b1;
    end

    assign hit = (cnt_q == lim - CNT_W'(1));
endmodule

// File: rtl/adc_rd_sclkgen.sv
// Serial clock generator: toggles on each tick while running, counts
// toggles and reports the index of the next rising edge.
module adc_rd_sclkgen #(
    parameter int FRAME_CLKS = 16,
    localparam int EDGE_W    = $clog2(2 * FRAME_CLKS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              tick,
    output logic              sclk,
    output logic              rise,
    output logic [EDGE_W-1:0] rise_num,
    output logic              last_fall
);
    localparam logic [EDGE_W-1:0] LAST_TOG = EDGE_W'(2 * FRAME_CLKS - 1);

    logic [EDGE_W-1:0] tog_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk  <= 1'b0;
            tog_q <= '0;
        end else if (!run) begin
            sclk  <= 1'b0;
            tog_q <= '0;
        end else if (tick) begin
            sclk  <= ~sclk;
            tog_q <= tog_q + 1'b1;
        end
    end

    assign rise      = run && tick && !sclk;
    assign rise_num  = {1'b0, tog_q[EDGE_W-1:1]} + EDGE_W'(1);
    assign last_fall = run && tick && sclk && (tog_q == LAST_TOG);
endmodule

// File: rtl/adc_rd_shreg.sv
// MSB-first capture register; each stage built by generate.
module adc_rd_shreg #(
    parameter int DATA_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [DATA_W-1:0] q
);
    for (genvar i = 0; i < DATA_W; i++) begin : g_stage
        logic nxt;
        if (i == 0) begin : g_head
            assign nxt = din;
        end else begin : g_body
            assign nxt = q[i-1];
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)        q[i] <= 1'b0;
            else if (shift_en) q[i] <= nxt;
        end
    end
endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W     = 12,
    parameter int FRAME_CLKS = 16,
    parameter int HALF_CYC   = 32,
    parameter int WAKE_CYC   = 500,
    parameter int TMO_CYC    = 1875,
    parameter int IDLE_CYC   = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    output logic              busy_o,
    output logic [DATA_W-1:0] data_o,
    output logic              valid_o,
    output logic              err_o,
    output logic              adc_cs_n_o,
    output logic              adc_sclk_o,
    output logic              adc_shdn_n_o,
    input  logic              adc_dout_i
);
    localparam int MAX_A   = (HALF_CYC > WAKE_CYC) ? HALF_CYC : WAKE_CYC;
    localparam int MAX_B   = (TMO_CYC > IDLE_CYC) ? TMO_CYC : IDLE_CYC;
    localparam int LIM_MAX = (MAX_A > MAX_B) ? MAX_A : MAX_B;
    localparam int CNT_W   = $clog2(LIM_MAX + 1);
    localparam int EDGE_W  = $clog2(2 * FRAME_CLKS);
    localparam logic [EDGE_W-1:0] FIRST_BIT = EDGE_W'(2);
    localparam logic [EDGE_W-1:0] LAST_BIT  = EDGE_W'(DATA_W + 1);

    rd_state_e         state_q, state_d;
    logic [CNT_W-1:0]  lim;
    logic              tmr_hit, tmr_clr;
    logic              arm_q, eoc_ok;
    logic              sclk_q, rise, last_fall;
    logic [EDGE_W-1:0] rise_num;
    logic              sample_en;
    logic [DATA_W-1:0] sh_q;

    // phase length for the timer
    always_comb begin
        unique case (state_q)
            ST_WAKE:  lim = CNT_W'(WAKE_CYC);
            ST_CONV:  lim = CNT_W'(TMO_CYC);
            ST_SHIFT: lim = CNT_W'(HALF_CYC);
            ST_GAP:   lim = CNT_W'(IDLE_CYC);
            default:  lim = CNT_W'(1);
        endcase
    end

    adc_rd_tmr #(.CNT_W(CNT_W)) tmr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (tmr_clr),
        .lim   (lim),
        .hit   (tmr_hit)
    );

    adc_rd_sclkgen #(.FRAME_CLKS(FRAME_CLKS)) sclk_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .run       (state_q == ST_SHIFT),
        .tick      (tmr_hit),
        .sclk      (sclk_q),
        .rise      (rise),
        .rise_num  (rise_num),
        .last_fall (last_fall)
    );

    assign sample_en = rise && (rise_num >= FIRST_BIT) && (rise_num <= LAST_BIT);

    adc_rd_shreg #(.DATA_W(DATA_W)) shreg_i (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (sample_en),
        .din      (adc_dout_i),
        .q        (sh_q)
    );

    // end-of-conversion is armed once the line has been seen low
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 arm_q <= 1'b0;
        else if (state_q != ST_CONV) arm_q <= 1'b0;
        else if (!adc_dout_i)       arm_q <= 1'b1;
    end

    assign eoc_ok = arm_q && adc_dout_i;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i)   state_d = ST_WAKE;
            ST_WAKE:  if (tmr_hit)   state_d = ST_CONV;
            ST_CONV: begin
                if (eoc_ok)          state_d = ST_SHIFT;
                else if (tmr_hit)    state_d = ST_GAP;
            end
            ST_SHIFT: if (last_fall) state_d = ST_GAP;
            ST_GAP:   if (tmr_hit)   state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    assign tmr_clr = tmr_hit || (state_d != state_q);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // result and strobes
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_o  <= '0;
            valid_o <= 1'b0;
            err_o   <= 1'b0;
        end else begin
            valid_o <= (state_q == ST_SHIFT) && last_fall;
            err_o   <= (state_q == ST_CONV) && !eoc_ok && tmr_hit;
            if ((state_q == ST_SHIFT) && last_fall) data_o <= sh_q;
        end
    end

    // pin outputs
    always_comb begin
        busy_o       = (state_q != ST_IDLE);
        adc_cs_n_o   = !((state_q == ST_CONV) || (state_q == ST_SHIFT));
        adc_shdn_n_o = (state_q == ST_WAKE) || (state_q == ST_CONV) || (state_q == ST_SHIFT);
        adc_sclk_o   = sclk_q;
    end
endmodule

// File: rtl/adc_rd_ctrl_chk.sv
module adc_rd_ctrl_chk
    import adc_rd_pkg::*;
(
    input logic      clk,
    input logic      rst_n,
    input rd_state_e state,
    input logic      cs_n,
    input logic      sclk,
    input logic      shdn_n,
    input logic      busy,
    input logic      valid,
    input logic      err
);
    // R3
    sclk_low_in_conv_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONV) |-> !sclk);

    // R5
    sclk_idle_when_deselected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sclk);

    // R2
    cs_fall_after_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> (shdn_n && $past(shdn_n) && $past(busy)));

    // R6
    valid_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        valid |-> (cs_n && $past(!cs_n)));

    // R7
    err_at_cs_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (cs_n && $past(!cs_n) && !$past(sclk)));

    // R7
    strobes_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({valid, err}));

    // R8
    gap_after_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |=> (cs_n && busy));

    // R9
    shdn_released_while_selected_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_n |-> shdn_n);
endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk chk_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .state  (state_q),
    .cs_n   (adc_cs_n_o),
    .sclk   (adc_sclk_o),
    .shdn_n (adc_shdn_n_o),
    .busy   (busy_o),
    .valid  (valid_o),
    .err    (err_o)
);

// File: tb/adc_rd_ctrl_tb_top.sv
module adc_rd_ctrl_tb_top;
    localparam int H = 3;
    localparam int W = 10;
    localparam int T = 40;
    localparam int I = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic        dout = 1'b1;
    logic        busy, valid, err, cs_n, sclk, shdn_n;
    logic [11:0] data;

    always #4 clk = ~clk;

    adc_rd_ctrl #(
        .DATA_W(12), .FRAME_CLKS(16), .HALF_CYC(H),
        .WAKE_CYC(W), .TMO_CYC(T), .IDLE_CYC(I)
    ) dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start),
        .busy_o       (busy),
        .data_o       (data),
        .valid_o      (valid),
        .err_o        (err),
        .adc_cs_n_o   (cs_n),
        .adc_sclk_o   (sclk),
        .adc_shdn_n_o (shdn_n),
        .adc_dout_i   (dout)
    );

    int n_vec = 0;
    int n_bad = 0;
    int cycles = 0;
    int n_valid = 0;
    int n_err = 0;
    logic [11:0] last_data = '0;

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h at cycle %0d",
                     req, what, act, exp, cycles);
        end
    endtask

    // converter model: drives the data line on negative clock edges
    logic [11:0] a_word = '0;
    int a_clen = 0, a_lag = 0, a_mode = 0;
    int a_cnt = 0, a_fall = 0;
    bit a_eoc = 0;
    logic a_prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (cs_n) begin
            dout = 1'b1;
            a_cnt = 0; a_eoc = 0; a_fall = 0;
        end else if (!a_eoc) begin
            a_cnt++;
            if (a_mode == 2)                                 dout = 1'b1;
            else if (a_cnt <= a_lag)                         dout = 1'b1;
            else if (a_mode == 0 && a_cnt > a_lag + a_clen) begin
                dout = 1'b1; a_eoc = 1;
            end else                                         dout = 1'b0;
        end else if (a_prev_sclk && !sclk) begin
            a_fall++;
            dout = (a_fall <= 12) ? a_word[12-a_fall] : 1'b0;
        end
        a_prev_sclk = sclk;
    end

    // behavioural reference, advanced on each rising edge
    int m_ph = 0, m_cnt = 0, m_tog = 0, m_rn = 0;
    bit m_arm = 0, m_sclk = 0, m_valid = 0, m_err = 0;
    logic [11:0] m_sh = '0, m_data = '0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_cnt = 0; m_tog = 0; m_arm = 0; m_sclk = 0;
            m_valid = 0; m_err = 0; m_sh = '0; m_data = '0;
        end else begin
            m_valid = 0; m_err = 0;
            case (m_ph)
                0: if (start) begin m_ph = 1; m_cnt = 0; end
                1: if (m_cnt == W-1) begin m_ph = 2; m_cnt = 0; m_arm = 0; end
                   else m_cnt++;
                2: if (m_arm && dout) begin
                       m_ph = 3; m_cnt = 0; m_sclk = 0; m_tog = 0;
                   end else if (m_cnt == T-1) begin
                       m_ph = 4; m_cnt = 0; m_err = 1;
                   end else begin
                       m_cnt++;
                       if (!dout) m_arm = 1;
                   end
                3: if (m_cnt == H-1) begin
                       m_cnt = 0; m_sclk = !m_sclk; m_tog++;
                       if (m_sclk) begin
                           m_rn = (m_tog + 1) / 2;
                           if (m_rn >= 2 && m_rn <= 13) m_sh = {m_sh[10:0], dout};
                       end
                       if (m_tog == 32) begin m_ph = 4; m_data = m_sh; m_valid = 1; end
                   end else m_cnt++;
                default: if (m_cnt == I-1) begin m_ph = 0; m_cnt = 0; end
                         else m_cnt++;
            endcase
        end
    end

    // per-cycle comparison, away from the active edge
    always @(negedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            chk(0, "watchdog", "run length", cycles, 150000);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
        if (rst_n) begin
            if (valid) begin n_valid++; last_data = data; end
            if (err) n_err++;
            chk(cs_n === !(m_ph == 2 || m_ph == 3), "R2", "cs_n", cs_n, !(m_ph == 2 || m_ph == 3));
            chk(sclk === m_sclk, (m_ph == 2) ? "R3" : "R5", "sclk", sclk, m_sclk);
            chk(shdn_n === (m_ph >= 1 && m_ph <= 3), "R9", "shdn_n", shdn_n, (m_ph >= 1 && m_ph <= 3));
            chk(busy === (m_ph != 0), "R8", "busy", busy, (m_ph != 0));
            chk(valid === m_valid, "R6", "valid", valid, m_valid);
            chk(err === m_err, "R7", "err", err, m_err);
            chk(data === m_data, "R6", "data", data, m_data);
        end
    end

    task automatic run_frame(input logic [11:0] w, input int clen,
                             input int lg, input int md);
        a_word = w; a_clen = clen; a_lag = lg; a_mode = md;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (30) @(negedge clk);
        start = 1'b1;               // R8: ignored, controller busy
        @(negedge clk) start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        int v0, e0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R1
        chk(cs_n === 1'b1 && sclk === 1'b0 && shdn_n === 1'b0, "R1", "pins",
            {cs_n, sclk, shdn_n}, 3'b100);
        chk(busy === 1'b0 && valid === 1'b0 && err === 1'b0, "R1", "status",
            {busy, valid, err}, 3'b000);

        // normal reads with varied patterns, conversion lengths and lags
        foreach (pat_q[k]) begin
            v0 = n_valid; e0 = n_err;
            run_frame(pat_q[k], 12 + 4*k, k % 3, 0);
            chk(n_valid == v0 + 1 && n_err == e0, "R8", "frames per request", n_valid - v0, 1);
            chk(last_data === pat_q[k], "R6", "captured word", last_data, pat_q[k]);
            chk(shdn_n === 1'b0, "R9", "shdn after frame", shdn_n, 0);
        end

        // end-of-conversion never arrives
        v0 = n_valid; e0 = n_err;
        run_frame(12'h3C3, 0, 1, 1);
        chk(n_err == e0 + 1 && n_valid == v0, "R7", "timeout strobe", n_err - e0, 1);
        chk(last_data === pat_q[pat_q.size()-1], "R7", "data kept", last_data, pat_q[pat_q.size()-1]);

        // line stays high from the start: must not be taken as completion
        v0 = n_valid; e0 = n_err;
        run_frame(12'h0F0, 5, 0, 2);
        chk(n_err == e0 + 1 && n_valid == v0, "R4", "early high ignored", n_valid - v0, 0);

        // request held high: back-to-back frames separated by the gap
        v0 = n_valid;
        a_word = 12'h9A6; a_clen = 8; a_lag = 2; a_mode = 0;
        @(negedge clk) start = 1'b1;
        while (n_valid < v0 + 2) @(negedge clk);
        start = 1'b0;
        while (busy) @(negedge clk);
        @(negedge clk);
        chk(last_data === 12'h9A6, "R6", "held-start word", last_data, 12'h9A6);

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    logic [11:0] pat_q [$] = '{12'hA5C, 12'h550, 12'hFFF, 12'h001, 12'h800, 12'h000};
endmodule